// File: doc/BRIEF.md
# Odd-Ratio Near-Square Clock Divider

This block turns a stream of input ticks (a one-cycle enable on the system clock) into a slower output whose period is N ticks. An odd N cannot give an exact 50% duty cycle. The block therefore splits each output period into two halves: a long half of ceil(N/2) ticks and a short half of floor(N/2) ticks. One synchronous down counter times both halves. At every terminal count it reloads with the length of the half that comes next, and a phase flip-flop toggles at the same moment. The two phases of the output therefore differ by exactly one tick. An even N gives two equal halves.

All state changes on the single system clock edge, so no transient wrong counts appear while a boundary is being decoded. The ratio input is read only when the counter reloads. A new ratio can therefore be written at any time and takes effect cleanly at the next half-period boundary.

A mode input turns the output into a one-cycle pulse per full period instead of the square wave. A typical use takes a 2048 Hz tick and divides it by 195: long half 98 ticks, short half 97 ticks, about 10.5 Hz out.

Top module: `odd_clk_div`

## Requirements
- R1: While rst_ni is low, div_o and tc_o are 0. The first clock edge after release loads the counter with the long-half length, and a tick in that cycle is not counted.
- R2: tc_o is high only in a cycle where tick_i is high, and only for the tick that ends a half period. This gives two strobes per full output period.
- R3: In square mode (pulse_mode_i = 0), div_o toggles on the clock edge that ends a cycle with tc_o high, and holds its value otherwise.
- R4: For odd N, the output is low (phase 0) for ceil(N/2) ticks and then high for floor(N/2) ticks. The two phases sum to N.
- R5: For even N, both phases last N/2 ticks.
- R6: In pulse mode (pulse_mode_i = 1), div_o is high for exactly one clock cycle per N ticks. That cycle is the one after the tick that ends the high (short) half.
- R7: ratio_i is sampled only when the counter reloads. A change in the middle of a half leaves that half's length unchanged, and the new ratio sets the following halves.
- R8: A ratio of 0 or 1 behaves as a ratio of 2.
- R9: In cycles with tick_i low, neither the counter nor the output changes, and tc_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable, one input tick per high cycle |
| ratio_i | input | DIV_W | Division ratio N, read at each reload |
| pulse_mode_i | input | 1 | 1 selects the full-period pulse on div_o |
| div_o | output | 1 | Divided clock, or full-period pulse in pulse mode |
| tc_o | output | 1 | Half-period terminal-count strobe |

## Verification
Two situations can land in the same cycle.

The first is a ratio change arriving while a half period is running. The bench writes a new ratio one tick into the long half. It then measures that half, which must keep its old length, and the two halves after it, which must follow the new ratio.

The second is a tick arriving in the priming cycle right after reset. That tick must be dropped rather than counted or turned into a terminal count. The bench checks this by holding tick_i high across the release of reset and confirming that div_o moves only after one further tick.

// File: rtl/odd_div_pkg.sv
package odd_div_pkg;
  // phase 0 = long half (ceil), phase 1 = short half (floor)
  typedef enum logic {
    PH_LONG  = 1'b0,
    PH_SHORT = 1'b1
  } phase_e;
endpackage

// File: rtl/odd_div_split.sv
module odd_div_split #(
  parameter int DIV_W = 8,
  localparam int CNT_W = DIV_W - 1
) (
  input  logic [DIV_W-1:0] ratio_i,
  output logic [CNT_W-1:0] long_m1_o,
  output logic [CNT_W-1:0] short_m1_o
);
  logic [DIV_W-1:0] n_eff, half_lo, half_hi, lo_m1, hi_m1;
  logic unused_msb;

  always_comb begin
    n_eff   = (ratio_i < DIV_W'(2)) ? DIV_W'(2) : ratio_i;
    half_lo = n_eff >> 1;
    half_hi = half_lo + {{(DIV_W-1){1'b0}}, n_eff[0]};
    lo_m1   = half_lo - DIV_W'(1);
    hi_m1   = half_hi - DIV_W'(1);
  end

  assign long_m1_o  = hi_m1[CNT_W-1:0];
  assign short_m1_o = lo_m1[CNT_W-1:0];
  assign unused_msb = lo_m1[DIV_W-1] ^ hi_m1[DIV_W-1];
endmodule

// File: rtl/odd_div_counter.sv
module odd_div_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/odd_div_phase.sv
module odd_div_phase
  import odd_div_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   flip_i,
  input  logic   pulse_mode_i,
  output phase_e phase_o,
  output logic   div_o
);
  phase_e phase_q;
  logic   wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LONG;
      wrap_q  <= 1'b0;
    end else begin
      wrap_q <= flip_i && (phase_q == PH_SHORT);
      if (flip_i) phase_q <= (phase_q == PH_LONG) ? PH_SHORT : PH_LONG;
    end
  end

  assign phase_o = phase_q;
  assign div_o   = pulse_mode_i ? wrap_q : (phase_q == PH_SHORT);
endmodule

// File: rtl/odd_clk_div.sv
module odd_clk_div
  import odd_div_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] ratio_i,
  input  logic             pulse_mode_i,
  output logic             div_o,
  output logic             tc_o
);
  localparam int CNT_W = DIV_W - 1;

  logic             primed_q;
  logic             zero, term, load;
  logic [CNT_W-1:0] long_m1, short_m1, load_val;
  phase_e           phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  odd_div_split #(.DIV_W(DIV_W)) u_split (
    .ratio_i    (ratio_i),
    .long_m1_o  (long_m1),
    .short_m1_o (short_m1)
  );

  assign term     = tick_i && zero && primed_q;
  assign load     = !primed_q || term;
  // next half follows the current phase; priming starts the long half
  assign load_val = (!primed_q || phase == PH_SHORT) ? long_m1 : short_m1;

  odd_div_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (zero)
  );

  odd_div_phase u_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flip_i       (term),
    .pulse_mode_i (pulse_mode_i),
    .phase_o      (phase),
    .div_o        (div_o)
  );

  assign tc_o = term;
endmodule

// File: rtl/odd_clk_div_chk.sv
module odd_clk_div_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic pulse_mode_i,
  input logic div_o,
  input logic tc_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) !rst_ni |-> (!div_o && !tc_o));

  // R2
  tc_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> tick_i);

  // R3
  toggle_on_tc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !pulse_mode_i) |=> (pulse_mode_i || (div_o != $past(div_o))));

  // R3
  hold_no_tc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tc_o && !pulse_mode_i) |=> (pulse_mode_i || $stable(div_o)));

  // R6
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_mode_i && div_o) |=> !(pulse_mode_i && div_o));
endmodule

bind odd_clk_div odd_clk_div_chk u_chk (.*);

// File: tb/odd_clk_div_tb_top.sv
`timescale 1ns/1ps
module odd_clk_div_tb_top;
  localparam int DIV_W = 8;
  // ratio, long half, short half
  localparam int VEC [8][3] = '{
    '{195, 98, 97}, '{3, 2, 1}, '{7, 4, 3}, '{255, 128, 127},
    '{2, 1, 1},     '{8, 4, 4}, '{1, 1, 1}, '{0, 1, 1}
  };

  logic clk_i = 1'b0;
  logic rst_ni, tick_i, pulse_mode_i;
  logic [DIV_W-1:0] ratio_i;
  logic div_o, tc_o;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  odd_clk_div #(.DIV_W(DIV_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .ratio_i(ratio_i),
    .pulse_mode_i(pulse_mode_i), .div_o(div_o), .tc_o(tc_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int n, input bit mode);
    @(negedge clk_i);
    rst_ni = 1'b0; tick_i = 1'b0; ratio_i = DIV_W'(n); pulse_mode_i = mode;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // called at a negedge; returns at the next negedge with the tick applied
  task automatic one_tick(output int tc_seen);
    tick_i = 1'b1;
    #1;
    tc_seen = int'(tc_o);
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t;
    rst_ni = 1'b0; tick_i = 1'b0; ratio_i = DIV_W'(2); pulse_mode_i = 1'b0;

    // table walk: R4 odd, R5 even, R8 degenerate ratios
    for (int v = 0; v < 8; v++) begin
      int lo, hi, tcs;
      string req;
      lo = 0; hi = 0; tcs = 0;
      req = (VEC[v][0] < 2) ? "R8" : ((VEC[v][0] % 2) != 0) ? "R4" : "R5";
      do_reset(VEC[v][0], 1'b0);
      for (int k = 0; k < 2 * (VEC[v][1] + VEC[v][2]); k++) begin
        if (div_o) hi++; else lo++;
        one_tick(t);
        tcs += t;
      end
      chk(lo == 2 * VEC[v][1], {req, " low ticks"}, lo, 2 * VEC[v][1]);
      chk(hi == 2 * VEC[v][2], {req, " high ticks"}, hi, 2 * VEC[v][2]);
      chk(tcs == 4, "R2 strobes per two periods", tcs, 4);
      chk(div_o == 1'b0, "R3 back to low phase", int'(div_o), 0);
    end

    // R1: tick held across reset and priming
    @(negedge clk_i);
    rst_ni = 1'b0; ratio_i = DIV_W'(2); pulse_mode_i = 1'b0; tick_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(div_o == 1'b0, "R1 div_o in reset", int'(div_o), 0);
    chk(tc_o == 1'b0, "R1 tc_o in reset", int'(tc_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(div_o == 1'b0, "R1 priming tick dropped", int'(div_o), 0);
    tick_i = 1'b0;
    #1;
    chk(tc_o == 1'b0, "R2 no strobe without tick", int'(tc_o), 0);
    @(negedge clk_i);
    chk(tc_o == 1'b0, "R2 no strobe at zero count idle", int'(tc_o), 0);
    one_tick(t);
    chk(t == 1, "R2 strobe on ending tick", t, 1);
    chk(div_o == 1'b1, "R1 first counted tick toggles", int'(div_o), 1);

    // R9: idle cycles change nothing
    begin
      int moved, strobes;
      moved = 0; strobes = 0;
      do_reset(3, 1'b0);
      one_tick(t);
      one_tick(t);
      chk(div_o == 1'b1, "R4 long half of 3 is 2", int'(div_o), 1);
      for (int k = 0; k < 20; k++) begin
        @(negedge clk_i);
        if (div_o != 1'b1) moved++;
        if (tc_o) strobes++;
      end
      chk(moved == 0, "R9 output held while idle", moved, 0);
      chk(strobes == 0, "R9 no strobe while idle", strobes, 0);
      one_tick(t);
      chk(div_o == 1'b0, "R9 count resumed after idle", int'(div_o), 0);
    end

    // R6: pulse mode
    begin
      int pulses, dbl, tcs;
      bit prev;
      pulses = 0; dbl = 0; tcs = 0; prev = 1'b0;
      do_reset(5, 1'b1);
      for (int k = 0; k < 15; k++) begin
        one_tick(t);
        tcs += t;
        if (div_o) begin
          pulses++;
          if (prev) dbl++;
        end
        prev = div_o;
      end
      chk(pulses == 3, "R6 one pulse per period", pulses, 3);
      chk(dbl == 0, "R6 pulse is one cycle wide", dbl, 0);
      chk(tcs == 6, "R2 half strobes in pulse mode", tcs, 6);
      @(negedge clk_i);
      chk(div_o == 1'b0, "R6 pulse ends", int'(div_o), 0);
    end

    // R7: ratio change in the middle of a half
    begin
      int lo, hi;
      lo = 0; hi = 0;
      do_reset(5, 1'b0);
      if (div_o) hi++; else lo++;
      one_tick(t);
      ratio_i = DIV_W'(9);
      for (int k = 0; k < 11; k++) begin
        if (div_o) hi++; else lo++;
        one_tick(t);
      end
      chk(lo == 8, "R7 low ticks old 3 then new 5", lo, 8);
      chk(hi == 4, "R7 high ticks from new ratio", hi, 4);
      chk(div_o == 1'b1, "R7 phase after three halves", int'(div_o), 1);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule